// File: doc/BRIEF.md
# Swizzle Move Decode and Execute

This block decodes a vector register move that can reorder the elements of its source, and produces the moved value one cycle after the instruction is presented. The source operand is a sub-vector of four packed elements. A lane selector of four 2-bit fields picks, for each destination lane, the source element that lands there. The selector comes either from an 8-bit immediate inside the instruction word or from the low byte of the second source operand, depending on the encoding.

The reordering only takes effect when the sub-vector length input is non-zero. With a zero length, every form becomes a straight copy. The block also reports whether the destination belongs to the integer or the floating-point register file, and it flags encodings under its major opcode that it does not define. Words with any other major opcode belong to other units and produce no output at all.

Top module: `swz_move`

## Requirements
- R1: Only words whose bits 6:0 equal 7'b1010111 are claimed. Any other word gives out_valid=0 and out_illegal=0 in the following cycle.
- R2: Outputs are registered. A word accepted with in_valid in one cycle shows its result after the next rising clock edge. A synchronous reset clears every output to zero.
- R3: Immediate form: bits 14:12 = 3'b000, a function code in bits 31:28 and a selector in bits 27:20. Code 4'b0000 is an integer move (out_fp=0) and code 4'b0001 is a floating-point move (out_fp=1).
- R4: Lane i of out_data (bits i*ELEM_W +: ELEM_W, i=0..3) receives source element k, where k is the selector field at bits 2i+1:2i. Lane 0 is controlled by bits 1:0 and lane 3 by bits 7:6. A repeated k broadcasts one element to several lanes.
- R5: When sub_len is zero, every legal form copies src_vec to out_data unchanged, whatever the selector.
- R6: Register form: bits 14:12 = 3'b001 and a second code in bits 31:25. Value 7'd0 is an integer plain move and 7'd1 is a floating-point plain move. Both copy src_vec unchanged for any sub_len.
- R7: Register form with second code 7'd2 (integer) or 7'd3 (floating point) reorders the source using src_sel[7:0] as the selector, following R4.
- R8: Under the claimed opcode, any other funct3, function code or second code gives out_illegal=1, out_valid=0, out_data=0 and out_rd=0.
- R9: On a valid result, out_rd equals bits 11:7 of the accepted word.
- R10: When in_valid is low, or the result is not valid, out_valid, out_illegal, out_fp, out_rd and out_data are all zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| sub_len | input | SUBLEN_W (2) | Sub-vector length setting; zero disables the reordering |
| src_vec | input | LANES*ELEM_W (128) | First source operand, four packed elements, element 0 in the low bits |
| src_sel | input | ELEM_W (32) | Second source operand; its low byte is the selector in the register-swizzle form |
| out_valid | output | 1 | A legal move completed |
| out_illegal | output | 1 | An undefined encoding under the claimed opcode was seen |
| out_fp | output | 1 | The destination is in the floating-point register file |
| out_rd | output | 5 | Destination register index |
| out_data | output | LANES*ELEM_W (128) | Moved, possibly reordered, value |

## Verification
The assertions assume that reset is applied before the first accepted word and that the instruction and operand inputs are stable around each rising edge. The bench keeps to this by asserting reset first, then driving every input on the falling edge and holding it for a full cycle. Unknown values never reach instr or in_valid, because the bench initialises all inputs at time zero. The sweeps cover every selector value in both swizzle forms, every sub-vector length, and every undefined function code, so the lane-mapping checks exercise the full crossbar without random stimulus.

// File: rtl/swz_pkg.sv
package swz_pkg;
    localparam logic [6:0] OPC_VMOVE = 7'b1010111;
    localparam logic [2:0] F3_IMM    = 3'b000;
    localparam logic [2:0] F3_REG    = 3'b001;
    localparam int         RD_W      = 5;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_IMM  = 2'd1,
        SEL_OPND = 2'd2
    } sel_src_e;

    typedef struct packed {
        logic             claim;
        logic             legal;
        logic             is_fp;
        sel_src_e         sel_src;
        logic [RD_W-1:0]  rd;
        logic [7:0]       imm_sel;
    } dec_t;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
    import swz_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [3:0] fn_code;
    logic [6:0] reg_code;
    logic [2:0] f3;

    assign fn_code  = instr[31:28];
    assign reg_code = instr[31:25];
    assign f3       = instr[14:12];

    always_comb begin
        dec         = '0;
        dec.claim   = (instr[6:0] == OPC_VMOVE);
        dec.rd      = instr[11:7];
        dec.imm_sel = instr[27:20];
        dec.sel_src = SEL_NONE;
        if (dec.claim) begin
            if (f3 == F3_IMM) begin
                if (fn_code[3:1] == 3'b000) begin
                    dec.legal   = 1'b1;
                    dec.is_fp   = fn_code[0];
                    dec.sel_src = SEL_IMM;
                end
            end else if (f3 == F3_REG) begin
                if (reg_code[6:2] == 5'd0) begin
                    dec.legal   = 1'b1;
                    dec.is_fp   = reg_code[0];
                    dec.sel_src = reg_code[1] ? SEL_OPND : SEL_NONE;
                end
            end
        end
    end

    always_comb begin
        if (dec.legal) assert (dec.claim)
            else $error("p_legal_claimed_r8 failed");
    end
endmodule

// File: rtl/swz_permute.sv
module swz_permute #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 32,
    localparam int IDX_W = $clog2(LANES),
    localparam int SEL_W = LANES * IDX_W,
    localparam int VEC_W = LANES * ELEM_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic [VEC_W-1:0] din,
    output logic [VEC_W-1:0] dout
);
    logic [ELEM_W-1:0] elem [LANES];

    for (genvar e = 0; e < LANES; e++) begin : g_split
        assign elem[e] = din[e*ELEM_W +: ELEM_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx = sel[l*IDX_W +: IDX_W];
        assign dout[l*ELEM_W +: ELEM_W] = en ? elem[idx] : elem[l];
    end

    always_comb begin
        if (!en) assert (dout == din)
            else $error("p_copy_when_off_r5 failed");
    end
endmodule

// File: rtl/swz_move.sv
module swz_move
    import swz_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int ELEM_W   = 32,
    parameter int SUBLEN_W = 2,
    localparam int IDX_W   = $clog2(LANES),
    localparam int SEL_W   = LANES * IDX_W,
    localparam int VEC_W   = LANES * ELEM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [SUBLEN_W-1:0] sub_len,
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [ELEM_W-1:0]   src_sel,
    output logic                out_valid,
    output logic                out_illegal,
    output logic                out_fp,
    output logic [RD_W-1:0]     out_rd,
    output logic [VEC_W-1:0]    out_data
);
    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic             fp;
        logic [RD_W-1:0]  rd;
        logic [VEC_W-1:0] data;
    } res_t;

    dec_t              dec;
    logic [SEL_W-1:0]  sel_mux;
    logic              perm_en;
    logic [VEC_W-1:0]  perm_out;
    res_t              res_d, res_q;

    swz_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        case (dec.sel_src)
            SEL_IMM:  sel_mux = dec.imm_sel[SEL_W-1:0];
            SEL_OPND: sel_mux = src_sel[SEL_W-1:0];
            default:  sel_mux = '0;
        endcase
        perm_en = (dec.sel_src != SEL_NONE) && (sub_len != '0);
    end

    swz_permute #(
        .LANES  (LANES),
        .ELEM_W (ELEM_W)
    ) u_perm (
        .en   (perm_en),
        .sel  (sel_mux),
        .din  (src_vec),
        .dout (perm_out)
    );

    always_comb begin
        res_d = '0;
        if (in_valid && dec.claim) begin
            if (dec.legal) begin
                res_d.valid = 1'b1;
                res_d.fp    = dec.is_fp;
                res_d.rd    = dec.rd;
                res_d.data  = perm_out;
            end else begin
                res_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign out_illegal = res_q.illegal;
    assign out_fp      = res_q.fp;
    assign out_rd      = res_q.rd;
    assign out_data    = res_q.data;

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));
    p_foreign_r1: assert property (@(posedge clk) disable iff (rst)
        (instr[6:0] != OPC_VMOVE) |=> (!out_valid && !out_illegal));
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_data == '0));
    p_rd_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_valid || out_rd == $past(instr[11:7])));
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && out_rd == '0 && !out_fp));
endmodule

// File: tb/swz_move_tb_top.sv
module swz_move_tb_top;
    localparam int LANES = 4;
    localparam int EW    = 32;
    localparam int VW    = LANES * EW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [1:0]    sub_len = '0;
    logic [VW-1:0] src_vec = '0;
    logic [EW-1:0] src_sel = '0;
    logic          out_valid, out_illegal, out_fp;
    logic [4:0]    out_rd;
    logic [VW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    swz_move dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .sub_len(sub_len), .src_vec(src_vec), .src_sel(src_sel),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_fp(out_fp),
        .out_rd(out_rd), .out_data(out_data)
    );

    function automatic logic [VW-1:0] permute(logic [VW-1:0] v, logic [7:0] s);
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            int k;
            k = (s >> (2 * i)) % 4;
            r[i*EW +: EW] = v[k*EW +: EW];
        end
        return r;
    endfunction

    function automatic logic [31:0] imm_word(logic [3:0] fn, logic [7:0] s, logic [4:0] rd);
        return {fn, s, 5'd3, 3'b000, rd, 7'b1010111};
    endfunction

    function automatic logic [31:0] reg_word(logic [6:0] f7, logic [4:0] rd);
        return {f7, 5'd9, 5'd3, 3'b001, rd, 7'b1010111};
    endfunction

    task automatic check(string req, logic v, logic il, logic fp, logic [4:0] rd,
                         logic [VW-1:0] d);
        checks++;
        if (out_valid !== v || out_illegal !== il || out_fp !== fp ||
            out_rd !== rd || out_data !== d) begin
            errors++;
            $display("FAIL %s: got v=%b il=%b fp=%b rd=%0d data=%h exp v=%b il=%b fp=%b rd=%0d data=%h",
                     req, out_valid, out_illegal, out_fp, out_rd, out_data,
                     v, il, fp, rd, d);
        end
    endtask

    task automatic apply(logic vld, logic [31:0] w, logic [1:0] sl,
                         logic [VW-1:0] a, logic [EW-1:0] b);
        in_valid = vld; instr = w; sub_len = sl; src_vec = a; src_sel = b;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [VW-1:0] a;
        a = {32'hD0D0_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000};
        repeat (3) @(negedge clk);
        check("R2 reset", 0, 0, 0, 0, '0);
        rst = 1'b0;

        // R3 R4: immediate form, every selector, every non-zero length
        for (int sl = 1; sl < 4; sl++)
            for (int s = 0; s < 256; s++) begin
                apply(1, imm_word(4'(s % 2), 8'(s), 5'(s)), 2'(sl), a, '0);
                check((s % 2) ? "R3 fp imm swizzle" : "R4 int imm swizzle",
                      1, 0, 1'(s % 2), 5'(s), permute(a, 8'(s)));
            end

        // R4 broadcast: all lanes take element 2
        apply(1, imm_word(4'd0, 8'b10_10_10_10, 5'd7), 2'd1, a, '0);
        check("R4 broadcast", 1, 0, 0, 5'd7, {4{a[2*EW +: EW]}});

        // R5: zero length copies in every form
        for (int s = 0; s < 256; s += 17) begin
            apply(1, imm_word(4'd1, 8'(s), 5'd4), 2'd0, a, '0);
            check("R5 imm zero length", 1, 0, 1, 5'd4, a);
            apply(1, reg_word(7'd2, 5'd5), 2'd0, a, 32'(s));
            check("R5 reg zero length", 1, 0, 0, 5'd5, a);
        end

        // R6: plain moves never reorder
        for (int sl = 0; sl < 4; sl++) begin
            apply(1, reg_word(7'd0, 5'd11), 2'(sl), a, 32'h0000_001B);
            check("R6 int plain move", 1, 0, 0, 5'd11, a);
            apply(1, reg_word(7'd1, 5'd12), 2'(sl), a, 32'h0000_001B);
            check("R6 fp plain move", 1, 0, 1, 5'd12, a);
        end

        // R7: selector from operand, upper operand bits ignored
        for (int s = 0; s < 256; s++) begin
            apply(1, reg_word(7'(2 + s % 2), 5'd20), 2'd3, a, {24'hFFFF5A, 8'(s)});
            check("R7 operand swizzle", 1, 0, 1'(s % 2), 5'd20, permute(a, 8'(s)));
        end

        // R8: undefined codes
        for (int fn = 2; fn < 16; fn++) begin
            apply(1, imm_word(4'(fn), 8'h1B, 5'd6), 2'd1, a, '0);
            check("R8 bad imm code", 0, 1, 0, 0, '0);
        end
        for (int f7 = 4; f7 < 128; f7++) begin
            apply(1, reg_word(7'(f7), 5'd6), 2'd1, a, 32'h1B);
            check("R8 bad reg code", 0, 1, 0, 0, '0);
        end
        for (int f3 = 2; f3 < 8; f3++) begin
            apply(1, {4'd0, 8'h1B, 5'd3, 3'(f3), 5'd6, 7'b1010111}, 2'd1, a, '0);
            check("R8 bad funct3", 0, 1, 0, 0, '0);
        end

        // R1: other opcodes ignored
        apply(1, {4'd0, 8'h1B, 5'd3, 3'b000, 5'd6, 7'b1010011}, 2'd1, a, '0);
        check("R1 foreign opcode", 0, 0, 0, 0, '0);
        apply(1, {4'd0, 8'h1B, 5'd3, 3'b000, 5'd6, 7'b1010110}, 2'd1, a, '0);
        check("R1 low bits differ", 0, 0, 0, 0, '0);

        // R9: destination index sweep
        for (int rd = 0; rd < 32; rd++) begin
            apply(1, reg_word(7'd0, 5'(rd)), 2'd0, a, '0);
            check("R9 rd field", 1, 0, 0, 5'(rd), a);
        end

        // R10: idle cycle after a valid one
        apply(1, imm_word(4'd1, 8'hE4, 5'd9), 2'd2, a, '0);
        check("R2 one cycle latency", 1, 0, 1, 5'd9, a);
        apply(0, imm_word(4'd1, 8'hE4, 5'd9), 2'd2, a, '0);
        check("R10 idle", 0, 0, 0, 0, '0);

        // R2: synchronous reset clears a held result
        apply(1, imm_word(4'd0, 8'h1B, 5'd2), 2'd1, a, '0);
        rst = 1'b1;
        @(negedge clk);
        check("R2 reset clears", 0, 0, 0, 0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule